// File: doc/BRIEF.md
# Stereo Record Sample FIFO

This block buffers captured audio words between a codec-side producer and a host-side reader. The producer writes left and right samples as alternating 16-bit words, always starting a pair with the left word. The host takes one word per read, so it collects a pair in two reads, left then right. Storage is sixteen words, which is eight stereo pairs.

The block keeps an occupancy count and drives empty and full flags from it. An interrupt request is raised while the occupancy is at or above one of four selectable levels, to tell the host that the buffer is nearly full. A write that arrives while the buffer is full sets a sticky overrun flag. Once that flag is set, every further write is dropped until the host pulses the FIFO clear input. The clear input also resets the pointers, so the left/right pairing is aligned again. Read data comes straight from the head of the buffer: it is valid in the same cycle and reads as zero while the buffer is empty.

Top module: `stereo_rec_fifo`

## Requirements
- R1: After `rst_n` low or a one-cycle `fifo_clr`, `empty`=1, `full`=0, `level`=0, `overrun`=0 and `head_left`=1.
- R2: Words leave in the order they were accepted, and up to 16 words can be held at once.
- R3: `head_left` is 1 when the word at the head sits in an even slot counted from the last clear (a left sample) and 0 when it sits in an odd slot. The flag toggles on each accepted read.
- R4: A write while `full`=1 sets `overrun` on the next cycle and is dropped: `level` stays 16 and the stored words are unchanged.
- R5: `overrun` stays set until `fifo_clr` or reset. While it is set, every write is dropped, even when the buffer is not full.
- R6: `irq` is 1 exactly when `level` ≥ T. `thr_sel` picks T: 0 gives 4, 1 gives 8, 2 gives 12 and 3 gives 14.
- R7: A read while empty returns `rd_data`=0 and changes neither `level` nor `head_left`.
- R8: A write and a read in the same cycle on a buffer that is neither empty nor full leave `level` unchanged.
- R9: `empty` equals (`level`==0) and `full` equals (`level`==16) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous FIFO clear. Also clears the overrun flag |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | 16 | Sample word to store |
| rd_en | input | 1 | Host read strobe. Advances the head |
| thr_sel | input | 2 | Interrupt level select |
| rd_data | output | 16 | Word at the head. Zero when empty |
| head_left | output | 1 | The head word is a left-channel sample |
| empty | output | 1 | No words stored |
| full | output | 1 | 16 words stored |
| level | output | 5 | Occupancy, 0 to 16 |
| irq | output | 1 | Occupancy at or above the selected level |
| overrun | output | 1 | Sticky overrun error |

## Verification
The buffer is filled one word at a time to capacity. At every occupancy all four threshold selects are checked, which separates an off-by-one compare from a wrong level mapping. Paired reads then confirm the data order and the left/right marker. After that, a write at full and a write while the overrun flag is set confirm that writes are dropped. Reads from an empty buffer and streams of simultaneous write and read separate a pointer that moves on an empty read from one that stays put, and show any drift in the occupancy count.

// File: rtl/srf_pkg.sv
package srf_pkg;

  // Interrupt occupancy level chosen by a 2-bit select, derived from depth.
  function automatic int unsigned irq_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return depth / 4;
      2'd1:    return depth / 2;
      2'd2:    return (3 * depth) / 4;
      default: return depth - 2;
    endcase
  endfunction

  // Pointer advance with wrap at depth.
  function automatic int unsigned ptr_next(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/srf_ptr_ctrl.sv
module srf_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          ovr,
  output logic          push_ok,
  output logic          pop_ok
);
  import srf_pkg::*;

  logic ovr_set;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full && !ovr;
  assign pop_ok  = pop && !empty;
  assign ovr_set = push && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_next(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ptr_next(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ovr_set) ovr <= 1'b1;
    end
  end

  // R4: a write at full raises the overrun flag
  a_r4_full_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> ovr);
  // R5: overrun holds until clear
  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);
  // R4: a dropped write at full with no read keeps the buffer full
  a_r4_full_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> full);
  // R8: balanced traffic keeps occupancy
  a_r8_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !clr) |=> $stable(count));
  // R2: occupancy never exceeds depth
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R1: clear empties the buffer
  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !ovr && rd_ptr == '0));

endmodule

// File: rtl/srf_store.sv
module srf_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/srf_thresh.sv
module srf_thresh #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic [1:0]    sel,
  output logic          irq
);
  import srf_pkg::*;

  logic [CW-1:0] lim;

  assign lim = CW'(irq_level(sel, DEPTH));
  assign irq = (level >= lim);

  // R6: no request below the lowest selectable level
  a_r6_irq_floor: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (level >= CW'(DEPTH / 4)));
  // R6: a full buffer always requests
  a_r6_irq_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CW'(DEPTH)) |-> irq);

endmodule

// File: rtl/stereo_rec_fifo.sv
module stereo_rec_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    thr_sel,
  output logic [DW-1:0] rd_data,
  output logic          head_left,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level,
  output logic          irq,
  output logic          overrun
);
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;
  logic [DW-1:0] mem_rdata;

  srf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(wr_en), .pop(rd_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(level), .empty(empty), .full(full),
    .ovr(overrun), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  srf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_ok && !fifo_clr), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(mem_rdata)
  );

  srf_thresh #(.DEPTH(DEPTH)) u_thr (
    .clk(clk), .rst_n(rst_n), .level(level), .sel(thr_sel), .irq(irq)
  );

  assign rd_data   = empty ? '0 : mem_rdata;
  assign head_left = ~rd_ptr[0];

  // R7: an empty buffer reads as zero
  a_r7_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (rd_data == '0));
  // R7: a read on empty leaves the head marker alone
  a_r7_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !fifo_clr) |=> $stable(head_left));
  // R3: an accepted read flips the channel marker
  a_r3_marker_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !fifo_clr) |=> (head_left != $past(head_left)));
  // R9: flags are exclusive
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

endmodule

// File: tb/stereo_rec_fifo_bench.sv
module stereo_rec_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  thr_sel = 2'd0;
  logic [15:0] rd_data;
  logic        head_left, empty, full, irq, overrun;
  logic [4:0]  level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] sb[$];
  bit          m_ovr = 1'b0;
  int          m_rd  = 0;

  always #2.5 clk = ~clk;

  stereo_rec_fifo u_stereo_rec_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .thr_sel(thr_sel), .rd_data(rd_data), .head_left(head_left),
    .empty(empty), .full(full), .level(level), .irq(irq), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  function automatic int lim_of(input int s);
    case (s)
      0: return 4;
      1: return 8;
      2: return 12;
      default: return 14;
    endcase
  endfunction

  task automatic check_state();
    chk("R9 level", int'(level), sb.size());
    chk("R9 empty", int'(empty), int'(sb.size() == 0));
    chk("R9 full", int'(full), int'(sb.size() == 16));
    chk("R5 overrun", int'(overrun), int'(m_ovr));
    chk("R6 irq", int'(irq), int'(sb.size() >= lim_of(int'(thr_sel))));
    chk("R3 head_left", int'(head_left), int'((m_rd % 2) == 0));
  endtask

  // driver: one cycle of traffic; scoreboard compare on accepted reads
  task automatic step(input bit pu, input logic [15:0] d, input bit po);
    bit pre_full, pre_ovr, pop_ok, push_ok;
    wr_en = pu; wr_data = d; rd_en = po;
    #1;
    pre_full = (sb.size() == 16);
    pre_ovr  = m_ovr;
    pop_ok   = po && (sb.size() > 0);
    push_ok  = pu && !pre_full && !pre_ovr;
    if (po) begin
      if (pop_ok) chk("R2 order", int'(rd_data), int'(sb[0]));
      else        chk("R7 empty read", int'(rd_data), 0);
    end
    @(posedge clk);
    if (pop_ok) begin void'(sb.pop_front()); m_rd++; end
    if (push_ok) sb.push_back(d);
    if (pu && pre_full) m_ovr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    #1;
    check_state();
  endtask

  task automatic clear_fifo();
    fifo_clr = 1'b1;
    @(posedge clk);
    sb.delete(); m_ovr = 1'b0; m_rd = 0;
    @(negedge clk);
    fifo_clr = 1'b0;
    #1;
    check_state();
    chk("R1 clear head_left", int'(head_left), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset empty", int'(empty), 1);
    chk("R1 reset full", int'(full), 0);
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset overrun", int'(overrun), 0);
    chk("R1 reset head_left", int'(head_left), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // fill with interleaved L/R words, sweeping all thresholds at each level
    for (int i = 0; i <= 16; i++) begin
      for (int s = 0; s < 4; s++) begin
        thr_sel = 2'(s);
        #1;
        chk("R6 sweep", int'(irq), int'(i >= lim_of(s)));
      end
      if (i < 16) step(1'b1, 16'(((i % 2) ? 16'hB000 : 16'hA000) + i), 1'b0);
    end
    thr_sel = 2'd1;
    chk("R2 holds 16", int'(level), 16);

    // R4: write at full is dropped and flags overrun
    step(1'b1, 16'hDEAD, 1'b0);
    chk("R4 overrun set", int'(overrun), 1);
    chk("R4 level held", int'(level), 16);

    // R3: paired reads, left then right
    chk("R3 left first", int'(head_left), 1);
    step(1'b0, 16'h0, 1'b1);
    chk("R3 right next", int'(head_left), 0);
    step(1'b0, 16'h0, 1'b1);

    // R5: writes dropped while overrun even when not full
    step(1'b1, 16'hBEEF, 1'b0);
    chk("R5 dropped", int'(level), 14);
    for (int k = 0; k < 14; k++) step(1'b0, 16'h0, 1'b1);
    chk("R5 beef absent", int'(empty), 1);
    clear_fifo();
    chk("R5 cleared", int'(overrun), 0);

    // R7: reads on empty
    step(1'b0, 16'h0, 1'b1);
    step(1'b0, 16'h0, 1'b1);
    chk("R7 head unchanged", int'(head_left), 1);

    // R8: balanced traffic
    for (int k = 0; k < 3; k++) step(1'b1, 16'(16'h1100 + k), 1'b0);
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 16'(16'h2200 + k), 1'b1);
      chk("R8 level steady", int'(level), 3);
    end
    // push+pop on empty: pop ignored, push taken
    for (int k = 0; k < 3; k++) step(1'b0, 16'h0, 1'b1);
    step(1'b1, 16'h3333, 1'b1);
    chk("R7 empty push+pop", int'(level), 1);
    step(1'b0, 16'h0, 1'b1);

    // reset mid-traffic
    step(1'b1, 16'h4444, 1'b0);
    rst_n = 1'b0;
    #1;
    sb.delete(); m_ovr = 1'b0; m_rd = 0;
    check_state();
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule